// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a processor core and turns a set of raw request lines into one prioritised request with a vector number attached. It accepts a parameterised number of peripheral lines, a tick from an internal periodic timer, a non-maskable line and a hard-fault line. For each source it keeps a pending flag and an active flag. The timer and every peripheral line also have an enable bit and a programmable priority field.

Every cycle the controller picks the most urgent source that is pending and eligible. It raises a request to the core only if that source is strictly more urgent than the current execution priority. The current execution priority is derived from the set of handlers that are active. The core takes the vector with an acknowledge, which moves the source from pending to active. It signals the end of a handler with an end-of-interrupt strobe, which retires the most urgent active handler. Any handler it had pre-empted then becomes current again.

Source numbering is fixed and is also the vector number. The non-maskable line is 0, the hard fault is 1, the timer tick is 2 and peripheral line k is 3+k. A lower effective priority value means more urgency. The non-maskable line has the fixed value 0 and the hard fault has the fixed value 1. A programmable source with field p has the value 2+p. The idle execution priority is all ones.

Top module: `nvpic_top`

## Requirements
- R1: After reset no source is pending or active, `irq_req_o` is low and `exec_prio_o` reads the idle value (7 with 2-bit priority fields).
- R2: A request line high at a clock edge makes that source pending. If it is eligible and more urgent than the execution priority, `irq_req_o` is high after that edge, with `irq_vec_o` equal to the source number (NMI 0, fault 1, timer 2, peripheral k at 3+k).
- R3: Among eligible pending sources, the one with the lowest effective priority value is presented, and on equal values the lower source number wins.
- R4: The non-maskable source outranks the hard fault, and both outrank every programmable level.
- R5: A source whose enable bit is clear stays pending but is not presented. Setting its enable later presents it.
- R6: The global mask input hides the timer and all peripheral sources, but never the non-maskable or hard-fault sources.
- R7: An acknowledge while a request is presented clears that source's pending flag and sets its active flag. `exec_prio_o` then equals that source's effective priority.
- R8: While handlers are active, a pending source is presented only if its priority is strictly more urgent than `exec_prio_o`. Sources of equal or lower urgency remain pending.
- R9: An end-of-interrupt strobe retires the most urgent active handler. `exec_prio_o` returns to that of the handler it pre-empted, or to idle, and requests held back by R8 are then presented.
- R10: A software set strobe makes a source pending and a software clear strobe removes a pending flag, in both cases without a request line.
- R11: The timer tick is a separate source with its own enable bit and its own programmable priority. It ties with a peripheral of the same priority in favour of the timer (lower number).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request line |
| fault_i | input | 1 | Hard-fault request line |
| tick_i | input | 1 | Periodic timer exception request |
| irq_i | input | NUM_IRQ | Peripheral request lines |
| glb_mask_i | input | 1 | Global mask for all programmable-priority sources |
| cfg_we_i | input | 1 | Write strobe for one source's enable and priority |
| cfg_idx_i | input | IW | Source number being configured (writes to 0 and 1 have no effect) |
| cfg_en_i | input | 1 | Enable value written |
| cfg_prio_i | input | PRIO_BITS | Priority field written |
| pend_set_i | input | NSRC | Software strobes that make sources pending |
| pend_clr_i | input | NSRC | Software strobes that clear pending flags |
| irq_ack_i | input | 1 | Core takes the presented vector |
| eoi_i | input | 1 | Core finished its current handler |
| irq_req_o | output | 1 | A source can pre-empt the current execution priority |
| irq_vec_o | output | IW | Number of the presented source |
| exec_prio_o | output | EW | Current execution priority (idle when nothing active) |

## Verification
The bench drives a three-deep nest and then unwinds it. A design that derived execution priority from the last acknowledged source, and not from the whole active set, would report the wrong level after the first end-of-interrupt and would present the equal-priority request that was being held back. Ties are driven at the same priority level, both between two peripherals and between the timer and a peripheral. A reversed tie-break would present the higher number first. The global mask is raised while fixed-priority sources fire, and a design that masked them would drop the non-maskable and fault requests. A fault that arrives under an active non-maskable handler must wait. A disabled source that is enabled later, and software set and clear of pending flags, check that pending state lives apart from eligibility.

// File: rtl/nvpic_pkg.sv
package nvpic_pkg;
   localparam int SRC_NMI   = 0;
   localparam int SRC_FAULT = 1;
   localparam int SRC_TICK  = 2;
   localparam int SRC_IRQ0  = 3;
   localparam int N_FIXED   = 2;   // sources with hard-wired priority
   localparam int N_SYS     = 3;   // sources ahead of the peripheral lines
endpackage

// File: rtl/nvpic_cfg.sv
module nvpic_cfg #(
   parameter int NSRC = 35,
   parameter int PB   = 2,
   parameter int EW   = 3,
   parameter int IW   = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [IW-1:0]            idx_i,
   input  logic                     en_i,
   input  logic [PB-1:0]            prio_i,
   output logic [NSRC-1:0]          en_o,
   output logic [NSRC-1:0][EW-1:0]  eprio_o
);
   import nvpic_pkg::*;

   localparam logic [EW-1:0] PROG_BASE = EW'(N_FIXED);

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      if (s < N_FIXED) begin : g_fixed
         assign en_o[s]    = 1'b1;
         assign eprio_o[s] = EW'(s);
      end else begin : g_prog
         logic          en_q;
         logic [PB-1:0] prio_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q   <= 1'b0;
               prio_q <= '0;
            end else if (we_i && idx_i == IW'(s)) begin
               en_q   <= en_i;
               prio_q <= prio_i;
            end
         end
         assign en_o[s]    = en_q;
         assign eprio_o[s] = {{(EW-PB){1'b0}}, prio_q} + PROG_BASE;
      end
   end
endmodule

// File: rtl/nvpic_pend.sv
module nvpic_pend #(
   parameter int NSRC = 35,
   parameter int IW   = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] hw_i,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   input  logic            take_i,
   input  logic [IW-1:0]   take_idx_i,
   output logic [NSRC-1:0] pend_o
);
   for (genvar s = 0; s < NSRC; s++) begin : g_bit
      logic taken;
      assign taken = take_i && take_idx_i == IW'(s);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_o[s] <= 1'b0;
         else        pend_o[s] <= (pend_o[s] & ~taken & ~clr_i[s]) | hw_i[s] | set_i[s];
      end
   end
endmodule

// File: rtl/nvpic_pick.sv
module nvpic_pick #(
   parameter int N  = 35,
   parameter int EW = 3,
   parameter int IW = 6
) (
   input  logic [N-1:0]          cand_i,
   input  logic [N-1:0][EW-1:0]  prio_i,
   output logic                  found_o,
   output logic [IW-1:0]         idx_o,
   output logic [EW-1:0]         prio_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      prio_o  = '1;
      // scan downward; "<=" lets the lower index take a tie
      for (int s = N - 1; s >= 0; s--) begin
         if (cand_i[s] && (!found_o || prio_i[s] <= prio_o)) begin
            found_o = 1'b1;
            idx_o   = IW'(s);
            prio_o  = prio_i[s];
         end
      end
   end
endmodule

// File: rtl/nvpic_top.sv
module nvpic_top #(
   parameter int NUM_IRQ   = 32,
   parameter int PRIO_BITS = 2,
   localparam int NSRC = NUM_IRQ + nvpic_pkg::N_SYS,
   localparam int IW   = $clog2(NSRC),
   localparam int EW   = $clog2((1 << PRIO_BITS) + nvpic_pkg::N_FIXED + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 nmi_i,
   input  logic                 fault_i,
   input  logic                 tick_i,
   input  logic [NUM_IRQ-1:0]   irq_i,
   input  logic                 glb_mask_i,
   input  logic                 cfg_we_i,
   input  logic [IW-1:0]        cfg_idx_i,
   input  logic                 cfg_en_i,
   input  logic [PRIO_BITS-1:0] cfg_prio_i,
   input  logic [NSRC-1:0]      pend_set_i,
   input  logic [NSRC-1:0]      pend_clr_i,
   input  logic                 irq_ack_i,
   input  logic                 eoi_i,
   output logic                 irq_req_o,
   output logic [IW-1:0]        irq_vec_o,
   output logic [EW-1:0]        exec_prio_o
);
   import nvpic_pkg::*;

   localparam logic [EW-1:0]   IDLE      = '1;
   localparam logic [NSRC-1:0] PROG_MASK = ~NSRC'((1 << N_FIXED) - 1);

   if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_irq
      $error("nvpic_top: NUM_IRQ must lie in 1..32");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("nvpic_top: PRIO_BITS must lie in 1..8");
   end

   logic [NSRC-1:0]         en, pend, cand, hw_req;
   logic [NSRC-1:0]         active;
   logic [NSRC-1:0][EW-1:0] eprio;
   logic                    p_found, a_found, take, retire;
   logic [IW-1:0]           p_idx, a_idx;
   logic [EW-1:0]           p_prio, a_prio;

   assign hw_req = {irq_i, tick_i, fault_i, nmi_i};

   nvpic_cfg #(.NSRC(NSRC), .PB(PRIO_BITS), .EW(EW), .IW(IW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .idx_i(cfg_idx_i),
      .en_i(cfg_en_i), .prio_i(cfg_prio_i), .en_o(en), .eprio_o(eprio));

   nvpic_pend #(.NSRC(NSRC), .IW(IW)) u_pend (
      .clk(clk), .rst_n(rst_n), .hw_i(hw_req), .set_i(pend_set_i),
      .clr_i(pend_clr_i), .take_i(take), .take_idx_i(p_idx), .pend_o(pend));

   assign cand = pend & en & ~(glb_mask_i ? PROG_MASK : '0);

   nvpic_pick #(.N(NSRC), .EW(EW), .IW(IW)) u_pick_pend (
      .cand_i(cand), .prio_i(eprio), .found_o(p_found), .idx_o(p_idx), .prio_o(p_prio));

   nvpic_pick #(.N(NSRC), .EW(EW), .IW(IW)) u_pick_act (
      .cand_i(active), .prio_i(eprio), .found_o(a_found), .idx_o(a_idx), .prio_o(a_prio));

   assign exec_prio_o = a_found ? a_prio : IDLE;
   assign irq_req_o   = p_found && (p_prio < exec_prio_o);
   assign irq_vec_o   = p_idx;
   assign take        = irq_req_o && irq_ack_i;
   assign retire      = eoi_i && a_found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active <= '0;
      else begin
         for (int s = 0; s < NSRC; s++) begin
            if (take && p_idx == IW'(s))         active[s] <= 1'b1;
            else if (retire && a_idx == IW'(s))  active[s] <= 1'b0;
         end
      end
   end

   p_req_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> pend[irq_vec_o]);
   p_nmi_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[SRC_NMI] && exec_prio_o != '0) |-> (irq_req_o && irq_vec_o == IW'(SRC_NMI)));
   p_mask_fixed_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_mask_i && irq_req_o) |-> (irq_vec_o < IW'(N_FIXED)));
   p_ack_activates_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> active[$past(irq_vec_o)]);
   p_preempt_deeper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> exec_prio_o < $past(exec_prio_o));
   p_eoi_retires_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && !irq_ack_i && active != '0) |=> $countones(active) == $past($countones(active)) - 1);
endmodule

// File: tb/sim_nvpic_top.sv
`timescale 1ns/1ps
module sim_nvpic_top;
   localparam int NI   = 32;
   localparam int NSRC = NI + 3;
   localparam int IW   = $clog2(NSRC);
   localparam int EW   = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NSRC-1:0] src_req = '0, pset = '0, pclr = '0;
   logic glb_mask = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0, ack = 1'b0, eoi = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [1:0] cfg_prio = '0;
   logic req;
   logic [IW-1:0] vec;
   logic [EW-1:0] exec_p;

   int checks = 0, fails = 0;
   int exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;   // 250 MHz

   nvpic_top u0 (
      .clk(clk), .rst_n(rst_n), .nmi_i(src_req[0]), .fault_i(src_req[1]),
      .tick_i(src_req[2]), .irq_i(src_req[NSRC-1:3]), .glb_mask_i(glb_mask),
      .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en), .cfg_prio_i(cfg_prio),
      .pend_set_i(pset), .pend_clr_i(pclr), .irq_ack_i(ack), .eoi_i(eoi),
      .irq_req_o(req), .irq_vec_o(vec), .exec_prio_o(exec_p));

   function automatic logic [NSRC-1:0] b(input int s);
      return NSRC'(1) << s;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the core side acknowledges
   always @(negedge clk) begin
      if (ack) begin
         if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
         else begin
            automatic int e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk({t, " req"}, int'(req), 1);
            chk({t, " vec"}, int'(vec), e);
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic pulse(input logic [NSRC-1:0] v);
      step(); src_req = v;
      step(); src_req = '0;
   endtask

   task automatic cfg(input int s, input logic en, input logic [1:0] p);
      step(); cfg_we = 1'b1; cfg_idx = IW'(s); cfg_en = en; cfg_prio = p;
      step(); cfg_we = 1'b0;
   endtask

   task automatic accept(input int e, input string tag);
      step(); exp_q.push_back(e); tag_q.push_back(tag); ack = 1'b1;
      step(); ack = 1'b0;
   endtask

   task automatic end_isr();
      step(); eoi = 1'b1;
      step(); eoi = 1'b0;
   endtask

   task automatic look(input string tag, input int r, input int v, input int x);
      @(negedge clk);
      chk({tag, " req"}, int'(req), r);
      if (r != 0) chk({tag, " vec"}, int'(vec), v);
      chk({tag, " exec"}, int'(exec_p), x);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      look("R1 reset", 0, 0, 7);

      // nesting and ties: src6 p1, src12 p1, src8 p2, src3 p0
      cfg(6, 1, 1); cfg(12, 1, 1); cfg(8, 1, 2); cfg(3, 1, 0);
      pulse(b(6) | b(12) | b(8));
      look("R2 R3 tie to lower index", 1, 6, 7);
      accept(6, "R3 first winner");
      look("R7 exec after accept", 0, 0, 3);         // R8: 12 (eq) and 8 (lower) held
      pulse(b(3));
      look("R8 strictly higher presented", 1, 3, 3);
      accept(3, "R8 preempt");
      look("R7 nested exec", 0, 0, 2);
      end_isr();
      look("R9 resume pre-empted", 0, 0, 3);
      end_isr();
      look("R9 held request released", 1, 12, 7);
      accept(12, "R9 held p1");
      end_isr();
      accept(8, "R9 held p2");
      end_isr();
      look("R9 all retired", 0, 0, 7);

      // disabled source
      pulse(b(10));
      look("R5 disabled not presented", 0, 0, 7);
      cfg(10, 1, 3);
      look("R5 enabled later", 1, 10, 7);
      accept(10, "R5 source");
      end_isr();

      // global mask
      step(); glb_mask = 1'b1;
      pulse(b(8));
      look("R6 masked peripheral", 0, 0, 7);
      pulse(b(0));
      look("R6 R4 nmi unmasked", 1, 0, 7);
      accept(0, "R4 nmi");
      look("R4 nmi exec", 0, 0, 0);
      pulse(b(1));
      look("R8 fault waits under nmi", 0, 0, 0);
      end_isr();
      look("R6 fault unmasked", 1, 1, 7);
      accept(1, "R6 fault");
      end_isr();
      look("R6 peripheral still masked", 0, 0, 7);
      step(); glb_mask = 1'b0;
      look("R6 unmask releases", 1, 8, 7);
      accept(8, "R6 released");
      end_isr();

      // timer source tie with peripheral
      cfg(2, 1, 1); cfg(4, 1, 1);
      pulse(b(2) | b(4));
      look("R11 timer tie wins", 1, 2, 7);
      accept(2, "R11 timer");
      look("R11 timer exec", 0, 0, 3);
      end_isr();
      accept(4, "R11 peer");
      end_isr();

      // fixed ranks above programmable
      pulse(b(3) | b(1));
      look("R4 fault over p0", 1, 1, 7);
      accept(1, "R4 fault");
      end_isr();
      accept(3, "R4 p0 after fault");
      end_isr();
      pulse(b(0) | b(1));
      accept(0, "R4 nmi over fault");
      end_isr();
      accept(1, "R4 fault second");
      end_isr();

      // software pending control
      step(); pset = b(8);
      step(); pset = '0;
      look("R10 software set", 1, 8, 7);
      step(); pclr = b(8);
      step(); pclr = '0;
      look("R10 software clear", 0, 0, 7);

      repeat (4) step();
      if (exp_q.size() != 0) chk("scoreboard leftover", exp_q.size(), 0);
      report();
   end
endmodule